// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Sequencer

This block is the write path of a byte-wide nonvolatile store whose array is split into 64-byte pages, seen from a simple synchronous host bus. The first byte written while the block is idle opens a load window. Further bytes for the same page go into a page latch, and each byte has its own valid flag. The window stays open as long as each byte follows the previous accepted byte within a programmable number of clock edges. When that gap is exceeded, the block stops taking data and enters a timed programming phase. In that phase only the flagged bytes are copied into the backing array.

While programming runs, a host cannot read array data. A read returns a status byte instead. Its top bit is the inverse of bit 7 of the last accepted byte, and bit 6 flips on every status read. Once programming ends, reads return stored data again. A `busy` output covers the whole span from the opening write to the end of programming. A sticky `page_error` flag records a write that tried to leave the open page.

All timers are synchronous cycle counters with parameterised limits. The load timeout (`LOAD_TO`) and the programming time (`PROG_CYC`) can therefore be scaled from their physical values of roughly 150 µs and 3–10 ms down to a few cycles for simulation. The default array depth is reduced (`ADDR_W` = 11). Setting `ADDR_W` = 15 gives the full 32768 × 8 organisation.

Top module: `pgw_write_seq`

## Requirements
- R1: The address splits into a byte offset (bits 5..0) and a page number (bits ADDR_W-1..6). A write captured while idle opens a window, and `busy` is high in the following cycle.
- R2: Within a window, a write to the open page is accepted if it is captured no more than `LOAD_TO` clock edges after the previous accepted write. If `LOAD_TO` edges pass with no accepted write, the window closes at the `LOAD_TO`-th edge and programming starts. A later write is not part of the window.
- R3: Programming lasts `PROG_CYC` cycles. `busy` falls at exactly the edge `LOAD_TO + PROG_CYC` edges after the last accepted write.
- R4: After programming, each byte written during the window holds its new value. Every other byte of that page, and every other page, keeps its previous contents.
- R5: Bytes may be written in any order. When a byte is written more than once in a window, the last value written is the one programmed.
- R6: A write in an open window whose page number differs from the window's page is ignored, and it sets `page_error` in the next cycle. `page_error` stays high until the next opening write, which clears it in the cycle after it is captured.
- R7: A write captured during programming is dropped. It changes neither the array nor `page_error`.
- R8: A read captured during programming returns a status byte one cycle later. Bit 7 is the inverse of bit 7 of the last accepted write data, and bits 5..0 are zero.
- R9: Bit 6 of the status byte is 0 on the first status read of a window and inverts on every later status read in that programming phase.
- R10: A read captured while idle or loading returns the array byte at `addr` on `rdata` one cycle later. While loading, that is the old contents, not the latched bytes.
- R11: While reset is held, `busy`, `page_error` and `rdata` are all zero at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Byte write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, result on `rdata` next cycle |
| addr | input | ADDR_W | Byte address: page number above bit 6, offset below |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data or programming status |
| busy | output | 1 | High from the opening write until programming ends |
| page_error | output | 1 | Sticky flag for a write aimed outside the open page |

## Verification
The properties assume that `PROG_CYC` is at least 64, so that every latch slot is visited during programming. They also assume the host never raises `wr_en` and `rd_en` in the same cycle. The toggle and status-format properties compare only back-to-back status reads. The stimulus issues each access as a one-cycle strobe and never overlaps a read with a write. It reads only addresses whose contents the bench model already knows. Random windows keep their write gaps between 1 and `LOAD_TO` edges, and directed cases cover the exact gap limit, a gap one edge longer, a foreign page and writes during programming.

// File: rtl/pgw_pkg.sv
// Package: shared constants and the phase type of the page write sequencer.
// Assumes: pages are always 64 bytes of 8 bits.
package pgw_pkg;
    localparam int BYTE_W     = 8;
    localparam int PAGE_OFS_W = 6;
    localparam int PAGE_BYTES = 1 << PAGE_OFS_W;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_t;
endpackage

// File: rtl/pgw_tick_counter.sv
// Module: cycle counter with a parameterised limit, used both for the
// byte-load gap and for the programming time.
// Assumes: LIMIT >= 1; clear has priority over run.
module pgw_tick_counter #(
    parameter int LIMIT = 8,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          run_i,
    output logic [CW-1:0] count_o,
    output logic          expire_o
);
    // Count the cycles spent running since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_o <= '0;
        else if (clear_i) count_o <= '0;
        else if (run_i)   count_o <= count_o + 1'b1;
    end

    // The limit is reached on the cycle whose edge completes LIMIT counts.
    assign expire_o = run_i && !clear_i && (count_o == CW'(LIMIT - 1));
endmodule

// File: rtl/pgw_page_latch.sv
// Module: 64-slot page latch with one valid flag per slot and the page number
// of the open window.
// Assumes: open_i is only raised together with load_i; open_i clears every
// flag except the slot loaded in the same cycle.
module pgw_page_latch
    import pgw_pkg::*;
#(
    parameter int PAGE_W = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         open_i,
    input  logic                         load_i,
    input  logic [PAGE_OFS_W-1:0]        ofs_i,
    input  logic [PAGE_W-1:0]            page_i,
    input  logic [BYTE_W-1:0]            din_i,
    output logic [PAGE_W-1:0]            page_o,
    output logic [PAGE_BYTES-1:0]        flags_o,
    output logic [PAGE_BYTES*BYTE_W-1:0] bytes_o
);
    // Capture the page number of a newly opened window.
    always_ff @(posedge clk) begin
        if (!rst_n)      page_o <= '0;
        else if (open_i) page_o <= page_i;
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic              hit;
        logic              flag_q;
        logic [BYTE_W-1:0] byte_q;

        assign hit = load_i && (ofs_i == PAGE_OFS_W'(g));

        // Hold this slot's byte and valid flag across the window.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
                byte_q <= '0;
            end else begin
                if (open_i)   flag_q <= hit;
                else if (hit) flag_q <= 1'b1;
                if (hit)      byte_q <= din_i;
            end
        end

        assign flags_o[g]                 = flag_q;
        assign bytes_o[g*BYTE_W +: BYTE_W] = byte_q;
    end
endmodule

// File: rtl/pgw_array.sv
// Module: backing byte array with one synchronous write port and one
// combinational read port.
// Assumes: contents are undefined until written; no reset on the storage.
module pgw_array
    import pgw_pkg::*;
#(
    parameter int ADDR_W = 11,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [BYTE_W-1:0] rdata_o
);
    logic [BYTE_W-1:0] mem [DEPTH];

    // Commit one byte per cycle when asked.
    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/pgw_write_seq.sv
// Module: top of the page write sequencer. It opens a load window on the
// first write, keeps it open while the byte gaps stay within LOAD_TO edges,
// then programs for PROG_CYC cycles. During that time it walks the 64 latch
// slots once and commits the flagged ones. Reads during programming return
// the status byte.
// Assumes: PROG_CYC >= 64 so that the commit walk fits in the programming
// time; wr_en and rd_en are not raised in the same cycle.
module pgw_write_seq
    import pgw_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int LOAD_TO  = 8,
    parameter int PROG_CYC = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              busy,
    output logic              page_error
);
    localparam int PAGE_W = ADDR_W - PAGE_OFS_W;
    localparam int LCW    = $clog2(LOAD_TO + 1);
    localparam int PCW    = $clog2(PROG_CYC + 1);

    phase_t                       phase;
    logic                         in_prog;
    logic                         page_hit;
    logic                         open_win;
    logic                         accept;
    logic                         foreign;
    logic [PAGE_W-1:0]            page_q;
    logic [PAGE_BYTES-1:0]        flags;
    logic [PAGE_BYTES*BYTE_W-1:0] bytes;
    logic [LCW-1:0]               gap_cnt;
    logic                         gap_exp;
    logic [PCW-1:0]               prog_cnt;
    logic                         prog_exp;
    logic [PAGE_OFS_W-1:0]        walk_ofs;
    logic                         arr_we;
    logic [BYTE_W-1:0]            arr_rdata;
    logic                         last_b7;
    logic                         tog_q;

    assign in_prog  = (phase == PH_PROG);
    assign page_hit = (addr[ADDR_W-1:PAGE_OFS_W] == page_q);
    assign open_win = wr_en && (phase == PH_IDLE);
    assign accept   = open_win || (wr_en && (phase == PH_LOAD) && page_hit);
    assign foreign  = wr_en && (phase == PH_LOAD) && !page_hit;

    // Advance the phase: idle -> load on a write, load -> program on a gap
    // timeout, program -> idle when the programming time is used up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE: if (open_win) phase <= PH_LOAD;
                PH_LOAD: if (gap_exp)  phase <= PH_PROG;
                PH_PROG: if (prog_exp) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    pgw_tick_counter #(.LIMIT(LOAD_TO)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .run_i    (phase == PH_LOAD),
        .count_o  (gap_cnt),
        .expire_o (gap_exp)
    );

    pgw_tick_counter #(.LIMIT(PROG_CYC)) u_prog (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (!in_prog),
        .run_i    (in_prog),
        .count_o  (prog_cnt),
        .expire_o (prog_exp)
    );

    pgw_page_latch #(.PAGE_W(PAGE_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .open_i  (open_win),
        .load_i  (accept),
        .ofs_i   (addr[PAGE_OFS_W-1:0]),
        .page_i  (addr[ADDR_W-1:PAGE_OFS_W]),
        .din_i   (wdata),
        .page_o  (page_q),
        .flags_o (flags),
        .bytes_o (bytes)
    );

    // The first 64 programming cycles visit one latch slot each.
    assign walk_ofs = prog_cnt[PAGE_OFS_W-1:0];
    assign arr_we   = in_prog && (prog_cnt < PCW'(PAGE_BYTES)) && flags[walk_ofs];

    pgw_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .we_i    (arr_we),
        .waddr_i ({page_q, walk_ofs}),
        .wdata_i (bytes[walk_ofs*BYTE_W +: BYTE_W]),
        .raddr_i (addr),
        .rdata_o (arr_rdata)
    );

    // Remember bit 7 of the last accepted byte for data polling.
    always_ff @(posedge clk) begin
        if (!rst_n)      last_b7 <= 1'b0;
        else if (accept) last_b7 <= wdata[7];
    end

    // Toggle bit: cleared per window, flipped by each status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                tog_q <= 1'b0;
        else if (open_win)         tog_q <= 1'b0;
        else if (in_prog && rd_en) tog_q <= ~tog_q;
    end

    // Sticky page error: set by a foreign-page write, cleared by a new window.
    always_ff @(posedge clk) begin
        if (!rst_n)        page_error <= 1'b0;
        else if (open_win) page_error <= 1'b0;
        else if (foreign)  page_error <= 1'b1;
    end

    // Register read data: status while programming, array data otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (in_prog) rdata <= {~last_b7, tog_q, 6'b0};
            else         rdata <= arr_rdata;
        end
    end

    assign busy = (phase != PH_IDLE);

    logic unused_ok;
    assign unused_ok = ^gap_cnt;
endmodule

// File: rtl/pgw_write_seq_chk.sv
// Module: property checker for pgw_write_seq, attached by bind.
// Assumes: the same input rules as the top module.
module pgw_write_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic       busy,
    input logic       page_error,
    input logic [7:0] rdata,
    input logic       in_prog
);
    AST_OPEN_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en) |=> busy); // R1

    AST_OPEN_CLEARS_PERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en) |=> !page_error); // R6

    AST_PERR_RISES_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(page_error) |-> ($past(wr_en) && $past(busy) && !$past(in_prog))); // R6

    AST_PROG_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_prog && wr_en) |=> $stable(page_error)); // R7

    AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_prog && rd_en) |=> (rdata[5:0] == 6'd0)); // R8

    AST_STATUS_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_prog && rd_en && $past(in_prog && rd_en)) |=> (rdata[6] != $past(rdata[6]))); // R9
endmodule

bind pgw_write_seq pgw_write_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .busy       (busy),
    .page_error (page_error),
    .rdata      (rdata),
    .in_prog    (in_prog)
);

// File: tb/sim_pgw_write_seq.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random windows, checked against a
// byte model of the array kept in the bench.
module sim_pgw_write_seq;
    localparam int AW = 11;
    localparam int LT = 8;
    localparam int PC = 80;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          busy;
    logic          page_error;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] model [DEPTH];
    bit         known [DEPTH];
    logic [7:0] stg_d [64];
    bit         stg_v [64];
    logic [AW-7:0] stg_page;
    logic       stg_b7;

    always #2.5 clk = ~clk;

    pgw_write_seq #(.ADDR_W(AW), .LOAD_TO(LT), .PROG_CYC(PC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .busy(busy), .page_error(page_error)
    );

    function automatic logic [7:0] status_byte(input logic b7, input logic tog);
        return {~b7, tog, 6'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Both tasks are entered at a falling edge and return one cycle later.
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] q);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        q = rdata;
    endtask

    task automatic stage(input logic [AW-1:0] a, input logic [7:0] d);
        stg_page = a[AW-1:6];
        stg_v[a[5:0]] = 1'b1;
        stg_d[a[5:0]] = d;
        stg_b7 = d[7];
    endtask

    task automatic commit_model();
        for (int i = 0; i < 64; i++) begin
            if (stg_v[i]) begin
                model[{stg_page, 6'(i)}] = stg_d[i];
                known[{stg_page, 6'(i)}] = 1'b1;
            end
            stg_v[i] = 1'b0;
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a);
        logic [7:0] q;
        rd(a, q);
        chk(req, q, model[a]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL R3 watchdog actual=busy_stuck expected=idle");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        int unsigned seed;
        for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
        for (int i = 0; i < 64; i++) stg_v[i] = 1'b0;
        seed = $urandom(32'd2024);

        // R11: reset state
        repeat (3) @(negedge clk);
        chk("R11 busy", busy, 0);
        chk("R11 page_error", page_error, 0);
        chk("R11 rdata", rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R3, R10: full page 3, then exact busy fall edge
        for (int i = 0; i < 64; i++) begin
            wr({5'd3, 6'(i)}, 8'(i) ^ 8'hA5);
            stage({5'd3, 6'(i)}, 8'(i) ^ 8'hA5);
            if (i == 0) chk("R1 busy after opening write", busy, 1);
        end
        repeat (LT + PC - 1) @(negedge clk);
        chk("R3 busy before last program edge", busy, 1);
        @(negedge clk);
        chk("R3 busy falls on time", busy, 0);
        commit_model();
        for (int i = 0; i < 64; i++) rd_chk("R10 full page readback", {5'd3, 6'(i)});

        // R5, R8, R9, R7, R4: partial page with overwrite and status polling
        wr({5'd3, 6'd5}, 8'h3C);  stage({5'd3, 6'd5}, 8'h3C);
        rd({5'd3, 6'd5}, q);
        chk("R10 read during load returns old data", q, model[{5'd3, 6'd5}]);
        wr({5'd3, 6'd9}, 8'hF0);  stage({5'd3, 6'd9}, 8'hF0);
        wr({5'd3, 6'd5}, 8'h81);  stage({5'd3, 6'd5}, 8'h81);
        repeat (LT) @(negedge clk);
        rd({5'd3, 6'd5}, q); chk("R8 first status read", q, status_byte(stg_b7, 1'b0));
        rd({5'd3, 6'd5}, q); chk("R9 second status read toggles", q, status_byte(stg_b7, 1'b1));
        rd({5'd3, 6'd7}, q); chk("R9 third status read toggles back", q, status_byte(stg_b7, 1'b0));
        wr({5'd3, 6'd20}, 8'h11);
        chk("R7 write in programming leaves page_error", page_error, 0);
        rd({5'd3, 6'd5}, q); chk("R9 toggle after dropped write", q, status_byte(stg_b7, 1'b1));
        wait_idle();
        commit_model();
        rd_chk("R5 overwrite keeps last value", {5'd3, 6'd5});
        rd_chk("R4 written byte updated", {5'd3, 6'd9});
        rd_chk("R7 dropped write left byte", {5'd3, 6'd20});
        rd_chk("R4 unwritten byte kept", {5'd3, 6'd6});

        // R6: foreign-page write, stickiness and clearing
        wr({5'd4, 6'd0}, 8'h5A);  stage({5'd4, 6'd0}, 8'h5A);
        wr({5'd3, 6'd1}, 8'h77);
        chk("R6 page_error set", page_error, 1);
        wr({5'd4, 6'd2}, 8'h01);  stage({5'd4, 6'd2}, 8'h01);
        wait_idle();
        commit_model();
        chk("R6 page_error sticky", page_error, 1);
        rd_chk("R6 foreign write ignored", {5'd3, 6'd1});
        rd_chk("R4 page 4 byte 2", {5'd4, 6'd2});
        wr({5'd6, 6'd2}, 8'hEE);  stage({5'd6, 6'd2}, 8'hEE);
        chk("R6 page_error cleared by new window", page_error, 0);
        wait_idle();
        commit_model();

        // R2: gap of exactly LOAD_TO edges accepted, one more closes the window
        wr({5'd6, 6'd0}, 8'h12);  stage({5'd6, 6'd0}, 8'h12);
        repeat (LT - 1) @(negedge clk);
        wr({5'd6, 6'd1}, 8'h34);  stage({5'd6, 6'd1}, 8'h34);
        repeat (LT) @(negedge clk);
        wr({5'd6, 6'd2}, 8'h56);
        wait_idle();
        commit_model();
        rd_chk("R2 byte at gap limit programmed", {5'd6, 6'd1});
        rd_chk("R2 byte after timeout dropped", {5'd6, 6'd2});

        // Random windows: R2, R4, R5, R8, R9, R10
        for (int w = 0; w < 24; w++) begin
            logic [4:0] pg;
            int n;
            pg = 5'($urandom % 32);
            n = 1 + int'($urandom % 12);
            for (int k = 0; k < n; k++) begin
                logic [5:0] o;
                logic [7:0] d;
                o = 6'($urandom % 64);
                d = 8'($urandom);
                if (k > 0) repeat (int'($urandom % LT)) @(negedge clk);
                wr({pg, o}, d);
                stage({pg, o}, d);
            end
            repeat (LT) @(negedge clk);
            rd({pg, 6'd0}, q);
            chk("R8 random status bit 7", {31'd0, q[7]}, {31'd0, ~stg_b7});
            chk("R9 random first toggle", {31'd0, q[6]}, 0);
            wait_idle();
            commit_model();
            for (int r = 0; r < 8; r++) begin
                logic [AW-1:0] a;
                a = {pg, 6'($urandom % 64)};
                if (known[a]) rd_chk("R4 random readback", a);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule